// File: doc/BRIEF.md
# Oversampling Sync Pulse Generator

This block derives two timing strobes from a nanosecond time base. A clock-enable input marks each elapsed nanosecond. From a programmed cycle length in nanoseconds and an oversampling factor n, the block emits a cycle strobe once per cycle and a sample strobe n times per cycle. Both strobes come from the same tick count, so the sample strobes stay equally spaced and locked to the cycle strobe. Each sample strobe comes with the index of that sample inside the current cycle.

Raising the enable input captures the configuration and checks it with a short sequential division. The check confirms three things: the factor is in range, the cycle divides into n whole-nanosecond sample intervals, and each interval is no shorter than a configured floor. A broken rule raises an error flag but does not stop the block. The strobes keep running with a rounded-down interval, so the sample data is then not trustworthy. Dropping the enable input halts the strobes and clears the flag. The next rising edge of the enable input restarts the cycle from sample zero.

Top module: `osg_top`

## Requirements
- R1: After reset, sync_fast, sync_cycle, sample_idx and cfg_err are all 0.
- R2: cfg_err is 1 when the captured factor n is 0 or greater than N_MAX.
- R3: cfg_err is 1 when the captured cycle length is not an exact multiple of n.
- R4: cfg_err is 1 when the sample interval (cycle length / n) is below MIN_FAST_NS. When none of R2–R4 applies, cfg_err is 0.
- R5: The check finishes PERIOD_W+2 clocks after the clock edge that samples enable high. Ticks that arrive before it finishes produce no strobe.
- R6: After the check, the first tick produces sync_fast and sync_cycle together with sample_idx 0. sync_cycle then repeats every cycle-length ticks.
- R7: sync_fast fires every cycle-length/n ticks, which gives exactly n strobes per cycle.
- R8: With each sync_fast, sample_idx takes the number of that strobe within the cycle, counting from 0. It holds that value until the next sync_fast.
- R9: A strobe is high for exactly the one clock that follows a clock with ns_tick high. No strobe occurs in any other clock.
- R10: While enable is low, no strobe occurs and cfg_err is 0. A new enable restarts the cycle at sample 0.
- R11: With an invalid configuration, the block still runs: sync_cycle fires every cycle-length ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; a rising edge captures the configuration |
| ns_tick | input | 1 | Clock enable, one pulse per elapsed nanosecond |
| cycle_ns | input | PERIOD_W | Cycle length in nanoseconds |
| factor | input | N_W | Oversampling factor n |
| sync_fast | output | 1 | Sample strobe, n per cycle |
| sync_cycle | output | 1 | Cycle strobe |
| sample_idx | output | IDX_W | Index of the latest sample within the cycle |
| cfg_err | output | 1 | Configuration rejected |

## Verification
A reduced configuration with an 8-bit cycle field, N_MAX of 6 and a floor of 3 ns is swept over every cycle length from 0 to 40 and every factor from 0 to 7. This sweep separates the out-of-range, non-divisible and below-floor cases from one another and from the valid ones. Several valid configurations are then run for three full cycles, and every tick is compared against strobe positions and indices computed arithmetically. These runs cover n=1 (strobes always coincide), n at the maximum, and intermediate factors. Further runs check an invalid but running configuration, ticks sent during the check, and ticks sent while disabled.

// File: rtl/osg_pkg.sv
package osg_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CALC = 2'd1,
      ST_RUN  = 2'd2
   } osg_state_e;
endpackage

// File: rtl/osg_div.sv
module osg_div #(
   parameter int DW = 32,
   parameter int NW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] dividend,
   input  logic [NW-1:0] divisor,
   output logic [DW-1:0] quo,
   output logic [NW-1:0] rem,
   output logic          busy
);
   localparam int CW = $clog2(DW + 1);

   logic [CW-1:0] steps;
   logic [NW-1:0] dvs;
   logic [NW:0]   trial;

   assign trial = {rem, quo[DW-1]};
   assign busy  = (steps != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo   <= '0;
         rem   <= '0;
         dvs   <= '0;
         steps <= '0;
      end else if (start) begin
         quo   <= dividend;
         rem   <= '0;
         dvs   <= divisor;
         steps <= CW'(DW);
      end else if (busy) begin
         steps <= steps - 1'b1;
         if (trial >= {1'b0, dvs}) begin
            rem <= NW'(trial - {1'b0, dvs});
            quo <= {quo[DW-2:0], 1'b1};
         end else begin
            rem <= trial[NW-1:0];
            quo <= {quo[DW-2:0], 1'b0};
         end
      end
   end
endmodule

// File: rtl/osg_pulse.sv
module osg_pulse #(
   parameter int DW    = 32,
   parameter int IDX_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [DW-1:0]    cycle_len,
   input  logic [DW-1:0]    fast_len,
   output logic             fast_o,
   output logic             cycle_o,
   output logic [IDX_W-1:0] idx_o
);
   logic [DW-1:0]    cyc_cnt, fst_cnt, cyc_lim, fst_lim;
   logic [IDX_W-1:0] cur;
   logic             at_cycle, at_fast, cyc_end;

   assign cyc_lim  = (cycle_len == '0) ? '0 : cycle_len - 1'b1;
   assign fst_lim  = (fast_len  == '0) ? '0 : fast_len  - 1'b1;
   assign at_cycle = (cyc_cnt == '0);
   assign at_fast  = at_cycle || (fst_cnt == '0);
   assign cyc_end  = (cyc_cnt >= cyc_lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_cnt <= '0;
         fst_cnt <= '0;
         cur     <= '0;
         fast_o  <= 1'b0;
         cycle_o <= 1'b0;
         idx_o   <= '0;
      end else if (!run) begin
         cyc_cnt <= '0;
         fst_cnt <= '0;
         cur     <= '0;
         fast_o  <= 1'b0;
         cycle_o <= 1'b0;
         idx_o   <= '0;
      end else begin
         fast_o  <= tick && at_fast;
         cycle_o <= tick && at_cycle;
         if (tick) begin
            if (at_cycle) begin
               cur   <= '0;
               idx_o <= '0;
            end else if (at_fast) begin
               cur   <= cur + 1'b1;
               idx_o <= cur + 1'b1;
            end
            cyc_cnt <= cyc_end ? '0 : cyc_cnt + 1'b1;
            fst_cnt <= (cyc_end || fst_cnt >= fst_lim) ? '0 : fst_cnt + 1'b1;
         end
      end
   end

   a_r6_cycle_has_fast: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_o |-> fast_o);
   a_r8_idx_zero_on_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_o |-> (idx_o == '0));
   a_r9_strobe_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_o || cycle_o) |-> $past(tick && run));
   a_r8_idx_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !fast_o) |-> $stable(idx_o));
endmodule

// File: rtl/osg_top.sv
module osg_top #(
   parameter int PERIOD_W    = 32,
   parameter int N_W         = 8,
   parameter int N_MAX       = 100,
   parameter int MIN_FAST_NS = 10000,
   parameter int IDX_W       = $clog2(N_MAX)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic                ns_tick,
   input  logic [PERIOD_W-1:0] cycle_ns,
   input  logic [N_W-1:0]      factor,
   output logic                sync_fast,
   output logic                sync_cycle,
   output logic [IDX_W-1:0]    sample_idx,
   output logic                cfg_err
);
   import osg_pkg::*;

   localparam logic [PERIOD_W-1:0] FLOOR = PERIOD_W'(MIN_FAST_NS);
   localparam logic [N_W-1:0]      NLIM  = N_W'(N_MAX);

   generate
      if (N_MAX < 1)                       $error("N_MAX must be positive");
      if ((1 << N_W) <= N_MAX)             $error("N_W too narrow for N_MAX");
      if ((1 << IDX_W) < N_MAX)            $error("IDX_W too narrow");
      if (PERIOD_W < 2)                    $error("PERIOD_W too small");
      if (MIN_FAST_NS >= (1 << PERIOD_W) && PERIOD_W < 31) $error("floor exceeds period range");
   endgenerate

   osg_state_e          state;
   logic [PERIOD_W-1:0] cyc_q, quo;
   logic [N_W-1:0]      n_q, rem;
   logic                start, busy, calc_done, bad;
   logic                floor_bad;

   generate
      if (MIN_FAST_NS == 0) begin : g_nofloor
         assign floor_bad = 1'b0;
      end else begin : g_floor
         assign floor_bad = (quo < FLOOR);
      end
   endgenerate

   assign start     = (state == ST_IDLE) && enable;
   assign calc_done = (state == ST_CALC) && !busy;
   assign bad       = (n_q == '0) || (n_q > NLIM) || (rem != '0) || floor_bad;

   osg_div #(.DW(PERIOD_W), .NW(N_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .dividend (cycle_ns),
      .divisor  (factor),
      .quo      (quo),
      .rem      (rem),
      .busy     (busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cyc_q   <= '0;
         n_q     <= '0;
         cfg_err <= 1'b0;
      end else if (!enable) begin
         state   <= ST_IDLE;
         cfg_err <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               cyc_q <= cycle_ns;
               n_q   <= factor;
               state <= ST_CALC;
            end
            ST_CALC: if (calc_done) begin
               cfg_err <= bad;
               state   <= ST_RUN;
            end
            default: ;
         endcase
      end
   end

   osg_pulse #(.DW(PERIOD_W), .IDX_W(IDX_W)) u_pulse (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       ((state == ST_RUN) && enable),
      .tick      (ns_tick),
      .cycle_len (cyc_q),
      .fast_len  (quo),
      .fast_o    (sync_fast),
      .cycle_o   (sync_cycle),
      .idx_o     (sample_idx)
   );

   a_r10_idle_no_err: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !cfg_err);
   a_r5_quiet_in_calc: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CALC) |=> !sync_fast && !sync_cycle);
   a_r10_quiet_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !sync_fast && !sync_cycle);
   a_r2_factor_range: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_RUN) && (n_q == '0 || n_q > NLIM)) |-> cfg_err);
endmodule

// File: tb/sim_osg_top.sv
module sim_osg_top;
   localparam int CLK_NS = 10;
   localparam int PW = 8;
   localparam int NW = 4;
   localparam int NMAX = 6;
   localparam int MINF = 3;
   localparam int IW = 3;

   logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, ns_tick = 1'b0;
   logic [PW-1:0] cycle_ns = '0;
   logic [NW-1:0] factor = '0;
   logic sync_fast, sync_cycle, cfg_err;
   logic [IW-1:0] sample_idx;
   int n_tests = 0, n_fail = 0;

   always #(CLK_NS/2) clk = ~clk;

   osg_top #(.PERIOD_W(PW), .N_W(NW), .N_MAX(NMAX), .MIN_FAST_NS(MINF), .IDX_W(IW)) u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .ns_tick(ns_tick),
      .cycle_ns(cycle_ns), .factor(factor), .sync_fast(sync_fast),
      .sync_cycle(sync_cycle), .sample_idx(sample_idx), .cfg_err(cfg_err));

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   // one tick, then sample after the edge that registers it, then a quiet clock
   task automatic tick_once(output logic f, output logic c, output int ix, output logic quiet);
      ns_tick = 1'b1; step(); ns_tick = 1'b0;
      @(negedge clk); f = sync_fast; c = sync_cycle; ix = int'(sample_idx);
      step(); @(negedge clk); quiet = !sync_fast && !sync_cycle;
      step();
   endtask

   task automatic configure(input int cyc, input int n);
      enable = 1'b0; step(); step();
      cycle_ns = PW'(cyc); factor = NW'(n);
      enable = 1'b1;
      for (int i = 0; i < PW + 4; i++) step();
   endtask

   function automatic int exp_err(input int cyc, input int n);
      if (n == 0 || n > NMAX) return 1;
      if (cyc % n != 0) return 1;
      if (cyc / n < MINF) return 1;
      return 0;
   endfunction

   task automatic run_valid(input int cyc, input int n);
      int q; logic f, c, qt; int ix;
      configure(cyc, n);
      q = cyc / n;
      chk("R4 valid cfg", int'(cfg_err), 0);
      for (int t = 0; t < 3 * cyc; t++) begin
         tick_once(f, c, ix, qt);
         chk("R6 sync_cycle", int'(c), int'(t % cyc == 0));
         chk("R7 sync_fast", int'(f), int'(t % q == 0));
         if (f) chk("R8 sample_idx", ix, (t % cyc) / q);
         chk("R9 one clock wide", int'(qt), 1);
      end
   endtask

   initial begin
      logic f, c, qt; int ix; int fired;
      #(CLK_NS * 3);
      @(negedge clk);
      chk("R1 sync_fast", int'(sync_fast), 0);
      chk("R1 sync_cycle", int'(sync_cycle), 0);
      chk("R1 sample_idx", int'(sample_idx), 0);
      chk("R1 cfg_err", int'(cfg_err), 0);
      rst_n = 1'b1; step();

      // R2 R3 R4 exhaustive sweep
      for (int cyc = 0; cyc <= 40; cyc++)
         for (int n = 0; n < 8; n++) begin
            configure(cyc, n);
            @(negedge clk);
            chk("R2/R3/R4 cfg_err sweep", int'(cfg_err), exp_err(cyc, n));
         end

      run_valid(12, 1);
      run_valid(12, 2);
      run_valid(12, 4);
      run_valid(18, 6);
      run_valid(24, 3);

      // R5 ticks during the check are ignored
      enable = 1'b0; step(); step();
      cycle_ns = 8'd12; factor = 4'd2; enable = 1'b1;
      step();
      fired = 0;
      for (int i = 0; i < PW / 2; i++) begin
         ns_tick = 1'b1; step(); @(negedge clk);
         if (sync_fast || sync_cycle) fired++;
      end
      ns_tick = 1'b0;
      chk("R5 no strobe during check", fired, 0);
      for (int i = 0; i < PW; i++) step();
      tick_once(f, c, ix, qt);
      chk("R5 first tick after check is cycle start", int'(c), 1);
      chk("R6 first tick fast", int'(f), 1);
      chk("R6 first tick idx", ix, 0);

      // R10 disabled: no strobes, no error; restart at sample 0
      configure(13, 2);
      enable = 1'b0; step();
      fired = 0;
      for (int i = 0; i < 10; i++) begin
         ns_tick = 1'b1; step(); @(negedge clk);
         if (sync_fast || sync_cycle) fired++;
      end
      ns_tick = 1'b0;
      chk("R10 no strobe while disabled", fired, 0);
      chk("R10 err cleared while disabled", int'(cfg_err), 0);
      configure(12, 4);
      for (int i = 0; i < 5; i++) tick_once(f, c, ix, qt);
      configure(12, 4);
      tick_once(f, c, ix, qt);
      chk("R10 restart cycle", int'(c), 1);
      chk("R10 restart idx", ix, 0);

      // R11 invalid config keeps running
      configure(13, 2);
      chk("R11 err flagged", int'(cfg_err), 1);
      for (int t = 0; t < 39; t++) begin
         tick_once(f, c, ix, qt);
         chk("R11 sync_cycle continues", int'(c), int'(t % 13 == 0));
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(CLK_NS * 190000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule